// File: doc/BRIEF.md
# Shared Time-of-Day Clock with Comparator and CPU Timers

This block keeps one time-of-day count that several CPU ports share. After reset the count is stopped at zero. It starts running only when one of the ports issues a set command. From then on, every step pulse advances it by one microsecond unit. In the default setup that unit is bit 12, counting from the least significant bit.

Each port can read the clock. A read returns a stamp followed by that port's own programmable extension field. Stamps on one port never repeat: when the count has not moved since that port's last stamp, the next stamp is one higher in the low-order bits below the unit bit.

A single comparator raises a level interrupt request while the count is above its programmed value. Each CPU also has its own down-counting timer. The timer falls at the same rate as the clock and requests an interrupt while its value is negative.

Top module: `tod_clock_unit`

## Requirements
- R1: After reset the following hold:
  - the count is zero and stopped (`running_o` low);
  - the comparator holds all ones;
  - every CPU timer is zero;
  - every extension field is zero;
  - `cmp_irq_o` and `tmr_irq_o` are low.
- R2: While the clock is stopped, step pulses have no effect. A set command loads the count and starts it running. Apart from steps, nothing else changes the count.
- R3: While running, each step pulse adds 2^UNIT_SHIFT to the count (4096 by default).
- R4: One cycle after `rd_req_i[p]`, `rd_val_o[p]` pulses for one cycle. At the same time, port p's slice of `rd_data_o` carries the stamp in its upper TOD_W bits and port p's extension field in its lower EXT_W bits.
- R5: When several ports issue a set in the same cycle, the port with the lowest index wins.
- R6: On each port, the first read after reset or after any set returns the current count. A later read returns the count if it is above that port's previous stamp, and otherwise the previous stamp plus one. Each port keeps its own history.
- R7: `cmp_irq_o` is high exactly while the count is strictly above the comparator value (unsigned). A comparator write takes effect in the next cycle, so reloading with a larger value clears the request.
- R8: A timer write loads that CPU's timer. Each step while the clock runs subtracts 2^UNIT_SHIFT from every timer. Timers do not move while the clock is stopped.
- R9: `tmr_irq_o[c]` is high exactly while CPU c's timer is negative, meaning its top bit is set. The CPUs are independent of each other.
- R10: A write to port p's extension field shows up only in port p's later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Time-base step pulse |
| set_req_i | input | N_CPU | Set-clock command per port |
| set_val_i | input | N_CPU*64 | Value to load, one slice per port |
| rd_req_i | input | N_CPU | Store-clock read request per port |
| rd_val_o | output | N_CPU | Read result valid per port |
| rd_data_o | output | N_CPU*(64+EXT_W) | Stamp followed by extension field, per port |
| ext_wr_i | input | N_CPU | Extension field write per port |
| ext_val_i | input | N_CPU*EXT_W | Extension field value per port |
| cmp_wr_i | input | 1 | Comparator load |
| cmp_val_i | input | 64 | Comparator value |
| cmp_irq_o | output | 1 | Comparator interrupt request (level) |
| tmr_wr_i | input | N_CPU | CPU timer load per CPU |
| tmr_val_i | input | N_CPU*64 | CPU timer value per CPU |
| tmr_irq_o | output | N_CPU | CPU timer interrupt request per CPU |
| running_o | output | 1 | Count has been set and is running |

## Verification
Set, step and write commands update registers at the clock edge where they are sampled. The two interrupt levels and `running_o` are combinational views of those registers, so they can be checked at the next falling edge. A read result appears exactly one edge after the request, with a one-cycle valid pulse, and it uses the count as it stood before that edge. The bench drives every input on a falling edge, moves forward one edge at a time, and samples on the following falling edge. It keeps its own model of the count, which advances only through the same steps and sets it drives, and it computes every expected stamp from that model.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int TOD_W = 64;
  typedef logic [TOD_W-1:0] tod_t;

  // Stamp rule: raw count unless it would not exceed this port's last stamp.
  function automatic tod_t unique_stamp(input tod_t now, input tod_t last, input logic last_vld);
    if (last_vld && (now <= last)) return last + tod_t'(1);
    return now;
  endfunction

  function automatic tod_t timer_next(input tod_t cur, input tod_t inc);
    return cur - inc;
  endfunction
endpackage

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int N_CPU      = 2,
  parameter int UNIT_SHIFT = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   step_i,
  input  logic [N_CPU-1:0]       set_req_i,
  input  logic [N_CPU*TOD_W-1:0] set_val_i,
  output tod_t                   tod_o,
  output logic                   running_o,
  output logic                   set_fire_o,
  output logic                   tick_o
);
  localparam tod_t STEP_INC = tod_t'(1) << UNIT_SHIFT;

  tod_t tod_q;
  logic running_q;
  tod_t sel_val;

  // Fixed priority: lowest port index wins.
  always_comb begin
    sel_val = '0;
    for (int i = N_CPU - 1; i >= 0; i--) begin
      if (set_req_i[i]) sel_val = set_val_i[i*TOD_W +: TOD_W];
    end
  end

  assign set_fire_o = |set_req_i;
  assign tick_o     = running_q & step_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tod_q     <= '0;
      running_q <= 1'b0;
    end else if (set_fire_o) begin
      tod_q     <= sel_val;
      running_q <= 1'b1;
    end else if (tick_o) begin
      tod_q <= tod_q + STEP_INC;
    end
  end

  assign tod_o     = tod_q;
  assign running_o = running_q;

  AST_SET_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    set_fire_o |=> (running_q && tod_q == $past(sel_val))); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_fire_o && !tick_o) |=> $stable(tod_q)); // R2
  AST_STEP_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !set_fire_o) |=> (tod_q == $past(tod_q) + STEP_INC)); // R3
  AST_LOW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_req_i[0] |=> (tod_q == $past(set_val_i[TOD_W-1:0]))); // R5
endmodule

// File: rtl/tod_reader.sv
module tod_reader
  import tod_pkg::*;
#(
  parameter int EXT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_req_i,
  input  tod_t               tod_i,
  input  logic               set_fire_i,
  input  logic               ext_wr_i,
  input  logic [EXT_W-1:0]   ext_val_i,
  output logic               rd_val_o,
  output logic [TOD_W+EXT_W-1:0] rd_data_o
);
  tod_t             last_q;
  logic             last_vld_q;
  logic [EXT_W-1:0] ext_q;
  tod_t             stamp;

  assign stamp = unique_stamp(tod_i, last_q, last_vld_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q     <= '0;
      last_vld_q <= 1'b0;
      ext_q      <= '0;
      rd_val_o   <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_val_o <= rd_req_i;
      if (ext_wr_i) ext_q <= ext_val_i;
      if (rd_req_i) begin
        rd_data_o <= {stamp, ext_q};
        last_q    <= stamp;
      end
      if (set_fire_i) last_vld_q <= 1'b0;
      else if (rd_req_i) last_vld_q <= 1'b1;
    end
  end

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_i |=> rd_val_o); // R4
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req_i |=> !rd_val_o); // R4
  AST_STAMP_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && last_vld_q && !set_fire_i) |=>
      (rd_data_o[TOD_W+EXT_W-1:EXT_W] > $past(last_q))); // R6
endmodule

// File: rtl/cpu_timer.sv
module cpu_timer
  import tod_pkg::*;
#(
  parameter int UNIT_SHIFT = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic wr_i,
  input  tod_t val_i,
  output logic irq_o
);
  localparam tod_t STEP_INC = tod_t'(1) << UNIT_SHIFT;

  tod_t cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wr_i)   cnt_q <= val_i;
    else if (tick_i) cnt_q <= timer_next(cnt_q, STEP_INC);
  end

  assign irq_o = cnt_q[TOD_W-1];

  AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (cnt_q == $past(val_i))); // R8
  AST_TMR_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !wr_i) |=> (cnt_q == $past(cnt_q) - STEP_INC)); // R8
  AST_TMR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !wr_i) |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/tod_clock_unit.sv
module tod_clock_unit
  import tod_pkg::*;
#(
  parameter int N_CPU      = 2,
  parameter int UNIT_SHIFT = 12,
  parameter int EXT_W      = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           step_i,
  input  logic [N_CPU-1:0]               set_req_i,
  input  logic [N_CPU*TOD_W-1:0]         set_val_i,
  input  logic [N_CPU-1:0]               rd_req_i,
  output logic [N_CPU-1:0]               rd_val_o,
  output logic [N_CPU*(TOD_W+EXT_W)-1:0] rd_data_o,
  input  logic [N_CPU-1:0]               ext_wr_i,
  input  logic [N_CPU*EXT_W-1:0]         ext_val_i,
  input  logic                           cmp_wr_i,
  input  logic [TOD_W-1:0]               cmp_val_i,
  output logic                           cmp_irq_o,
  input  logic [N_CPU-1:0]               tmr_wr_i,
  input  logic [N_CPU*TOD_W-1:0]         tmr_val_i,
  output logic [N_CPU-1:0]               tmr_irq_o,
  output logic                           running_o
);
  localparam int RD_W = TOD_W + EXT_W;

  tod_t tod;
  logic set_fire;
  logic tick;
  tod_t cmp_q;

  tod_counter #(.N_CPU(N_CPU), .UNIT_SHIFT(UNIT_SHIFT)) counter_i (
    .clk(clk), .rst_n(rst_n), .step_i(step_i),
    .set_req_i(set_req_i), .set_val_i(set_val_i),
    .tod_o(tod), .running_o(running_o),
    .set_fire_o(set_fire), .tick_o(tick)
  );

  for (genvar p = 0; p < N_CPU; p++) begin : g_port
    tod_reader #(.EXT_W(EXT_W)) reader_i (
      .clk(clk), .rst_n(rst_n), .rd_req_i(rd_req_i[p]), .tod_i(tod),
      .set_fire_i(set_fire), .ext_wr_i(ext_wr_i[p]),
      .ext_val_i(ext_val_i[p*EXT_W +: EXT_W]),
      .rd_val_o(rd_val_o[p]), .rd_data_o(rd_data_o[p*RD_W +: RD_W])
    );
    cpu_timer #(.UNIT_SHIFT(UNIT_SHIFT)) timer_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_i(tmr_wr_i[p]),
      .val_i(tmr_val_i[p*TOD_W +: TOD_W]), .irq_o(tmr_irq_o[p])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        cmp_q <= '1;
    else if (cmp_wr_i) cmp_q <= cmp_val_i;
  end

  assign cmp_irq_o = tod > cmp_q;

  AST_CMP_RELOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr_i && cmp_val_i == '1) |=> !cmp_irq_o); // R7
  AST_CMP_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_o && !set_fire && !cmp_wr_i && !cmp_irq_o) |=> !cmp_irq_o); // R7
endmodule

// File: tb/tod_clock_unit_tb_top.sv
module tod_clock_unit_tb_top;
  localparam int N = 2;
  localparam int EW = 16;
  localparam int TW = 64;
  localparam int RW = TW + EW;
  localparam logic [TW-1:0] INC = 64'd4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step = 1'b0;
  logic [N-1:0] set_req = '0;
  logic [N*TW-1:0] set_val = '0;
  logic [N-1:0] rd_req = '0;
  logic [N-1:0] rd_val;
  logic [N*RW-1:0] rd_data;
  logic [N-1:0] ext_wr = '0;
  logic [N*EW-1:0] ext_val = '0;
  logic cmp_wr = 1'b0;
  logic [TW-1:0] cmp_val = '0;
  logic cmp_irq;
  logic [N-1:0] tmr_wr = '0;
  logic [N*TW-1:0] tmr_val = '0;
  logic [N-1:0] tmr_irq;
  logic running;

  int total = 0;
  int fails = 0;
  bit done = 0;
  logic [TW-1:0] exp_tod;
  logic [TW-1:0] base;

  always #2 clk = ~clk;

  tod_clock_unit #(.N_CPU(N), .UNIT_SHIFT(12), .EXT_W(EW)) dut_i (
    .clk(clk), .rst_n(rst_n), .step_i(step),
    .set_req_i(set_req), .set_val_i(set_val),
    .rd_req_i(rd_req), .rd_val_o(rd_val), .rd_data_o(rd_data),
    .ext_wr_i(ext_wr), .ext_val_i(ext_val),
    .cmp_wr_i(cmp_wr), .cmp_val_i(cmp_val), .cmp_irq_o(cmp_irq),
    .tmr_wr_i(tmr_wr), .tmr_val_i(tmr_val), .tmr_irq_o(tmr_irq),
    .running_o(running)
  );

  task automatic check(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_step();
    @(negedge clk); step = 1'b1;
    @(negedge clk); step = 1'b0;
  endtask

  task automatic do_read(input int p, input string req, input logic [TW-1:0] st, input logic [EW-1:0] ex);
    @(negedge clk); rd_req[p] = 1'b1;
    @(negedge clk);
    check({req, " valid"}, RW'(rd_val[p]), RW'(1));
    check(req, rd_data[p*RW +: RW], {st, ex});
    rd_req[p] = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 running", RW'(running), RW'(0));
    check("R1 cmp_irq", RW'(cmp_irq), RW'(0));
    check("R1 tmr_irq", RW'(tmr_irq), RW'(0));
    // R2/R6 reads while stopped; steps ignored
    do_read(1, "R1 R6 first read", 64'd0, 16'd0);
    for (int k = 0; k < 3; k++) do_step();
    check("R2 still stopped", RW'(running), RW'(0));
    check("R8 no timer decrement while stopped", RW'(tmr_irq), RW'(0));
    do_read(1, "R2 R6 step ignored, stamp bumped", 64'd1, 16'd0);
    // R2 set from port 1
    @(negedge clk); set_req = 2'b10; set_val[TW +: TW] = 64'h0123_4560_0000_0000;
    @(negedge clk); set_req = '0;
    check("R2 running after set", RW'(running), RW'(1));
    do_read(0, "R2 set value", 64'h0123_4560_0000_0000, 16'd0);
    // R5 simultaneous sets
    @(negedge clk); set_req = 2'b11;
    set_val[0 +: TW] = 64'h0200_0000_0000_0000;
    set_val[TW +: TW] = 64'h0300_0000_0000_0000;
    @(negedge clk); set_req = '0;
    exp_tod = 64'h0200_0000_0000_0000;
    do_read(1, "R5 lowest port wins", exp_tod, 16'd0);
    // R3 step sweep
    for (int k = 1; k <= 4; k++) begin
      do_step();
      exp_tod = exp_tod + INC;
      do_read(1, "R3 step advance", exp_tod, 16'd0);
    end
    // R6 uniqueness, per port
    for (int k = 0; k < 3; k++)
      do_read(0, "R6 port0 sequence", exp_tod + 64'(k), 16'd0);
    do_read(1, "R6 port1 independent", exp_tod + 64'd1, 16'd0);
    // R10 extension field
    @(negedge clk); ext_wr = 2'b01; ext_val[0 +: EW] = 16'hBEEF;
    @(negedge clk); ext_wr = '0;
    do_read(0, "R10 ext on port0", exp_tod + 64'd3, 16'hBEEF);
    do_read(1, "R10 port1 ext untouched", exp_tod + 64'd2, 16'd0);
    // R7 comparator
    @(negedge clk); cmp_wr = 1'b1; cmp_val = exp_tod + INC;
    @(negedge clk); cmp_wr = 1'b0;
    check("R7 below", RW'(cmp_irq), RW'(0));
    do_step(); exp_tod = exp_tod + INC;
    check("R7 equal", RW'(cmp_irq), RW'(0));
    do_step(); exp_tod = exp_tod + INC;
    check("R7 above", RW'(cmp_irq), RW'(1));
    @(negedge clk); cmp_wr = 1'b1; cmp_val = '1;
    @(negedge clk); cmp_wr = 1'b0;
    check("R7 reload clears", RW'(cmp_irq), RW'(0));
    // R8/R9 timers
    @(negedge clk); tmr_wr = 2'b11;
    tmr_val[0 +: TW] = 2 * INC; tmr_val[TW +: TW] = 64'h7FFF_FFFF_FFFF_FFFF;
    @(negedge clk); tmr_wr = '0;
    check("R9 both positive", RW'(tmr_irq), RW'(0));
    do_step(); do_step();
    check("R8 timer0 at zero", RW'(tmr_irq), RW'(0));
    do_step();
    check("R8 R9 timer0 negative only", RW'(tmr_irq), RW'(2'b01));
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule